// File: doc/BRIEF.md
# Block Transform I/O Sequencer

This block runs the data flow around a 64-point block-based FFT/IFFT engine. A one-cycle start strobe opens the loading of one block of complex samples. The samples go into a two-bank buffer, one sample for each cycle that input valid is high. After the last sample, a busy window of a configurable number of cycles stands in for the butterfly computation. The block then raises done. While done is high, a download enable streams the stored block out with a first-sample marker and an output valid.

Two banks let the next block load while the previous result is still being read. If a download ends and no new block has begun loading since that result was completed, done rises again and the same result can be read once more, for example to repeat part of a symbol as a guard interval. A clear strobe captures the transform direction and the scaling factor, drops any stored result and aborts a load or computation in progress. For the shortest period, the host enables the download as soon as done rises and starts the next block as soon as busy falls.

Top module: `xfrm_seq`

## Requirements
- R1: After reset, busy, done, out_vld and out_first are 0, and mode_inv and mode_scale are 0.
- R2: A cycle with cfg_clr high loads cfg_inv and cfg_scale into mode_inv and mode_scale, visible from the next cycle. The same strobe drops any stored result, so done is 0 afterwards, and it aborts a load or computation. Samples that arrive after a clear without a new start do not raise busy.
- R3: blk_start, when loading and computing are idle and no second result is held, begins a load. During the load, each cycle with in_vld high stores one sample {in_re, in_im} at the next position, and the 64th stored sample ends the load. in_vld outside a load is ignored.
- R4: busy rises in the cycle after the edge that stores the 64th sample. It stays high for exactly PROC_CYC cycles.
- R5: When no download is active, done is high from the first cycle after busy falls. It stays high until a download is accepted.
- R6: An edge that samples dl_en and done both high starts a download. out_vld is high for exactly 64 consecutive cycles, starting two cycles after that edge. out_first is high only with the first of those samples, and out_re/out_im deliver the samples in load order.
- R7: If a download ends and no new load has begun since its result was completed, done is high again in the cycle after the last sample. A further download delivers the same samples.
- R8: If a new load began while the result was stored, done stays 0 after that result's download until the new result completes.
- R9: blk_start while busy is high is ignored.
- R10: A result that completes during a download is held. It takes over when the download ends: done is high in the cycle after the last sample, and the next download delivers the new block. While such a result is held, blk_start is ignored.
- R11: A result that completes while no download is active replaces a stored result that was never downloaded.
- R12: dl_en while done is 0 is ignored: no out_vld follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_clr | input | 1 | Clear strobe: captures the configuration and drops stored results |
| cfg_inv | input | 1 | Transform direction to capture (1 = inverse) |
| cfg_scale | input | SW | Scaling factor to capture |
| blk_start | input | 1 | One-cycle block start strobe |
| in_vld | input | 1 | Input sample valid |
| in_re | input | DW | Input sample, real part |
| in_im | input | DW | Input sample, imaginary part |
| dl_en | input | 1 | Download enable, acted on while done is high |
| busy | output | 1 | Computation window active |
| done | output | 1 | A result is ready for download |
| out_first | output | 1 | Marks the first sample of a download |
| out_vld | output | 1 | Output sample valid |
| out_re | output | DW | Output sample, real part |
| out_im | output | DW | Output sample, imaginary part |
| mode_inv | output | 1 | Captured transform direction |
| mode_scale | output | SW | Captured scaling factor |

## Verification
The bench builds the block with NPTS=64, DW=8, SW=3 and PROC_CYC=24. A full 64-sample block is therefore exercised, while the compute window stays shorter than a 64-cycle download. With that setting, a result can complete in the middle of a download of the previous one, which brings the held-result hand-over and the refused start during that hold within reach. A load started together with a download, with random input gaps, checks that re-download is withheld once a new block has begun.

// File: rtl/xs_pkg.sv
package xs_pkg;
  typedef enum logic [1:0] {
    IN_IDLE = 2'd0,
    IN_LOAD = 2'd1,
    IN_BUSY = 2'd2
  } in_state_e;
endpackage

// File: rtl/xs_load_ctl.sv
module xs_load_ctl
  import xs_pkg::*;
#(
  parameter int NPTS = 64,
  parameter int PROC_CYC = 320,
  localparam int PW = $clog2(NPTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          blk_start,
  input  logic          in_vld,
  input  logic          res_rdy,
  input  logic          rbank,
  input  logic          pend,
  output logic          busy,
  output logic          start_acc,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [PW-1:0] wr_addr,
  output logic          comp_end
);
  localparam int CW = $clog2(PROC_CYC + 1);

  in_state_e     st_q, st_d;
  logic [PW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] pcnt_q, pcnt_d;
  logic          bank_q, bank_d;
  logic          last_smp;
  logic          st_en, wptr_en, pcnt_en, bank_en;

  always_comb begin
    start_acc = (st_q == IN_IDLE) && blk_start && !pend && !clr;
    wr_en     = (st_q == IN_LOAD) && in_vld && !clr;
    last_smp  = wr_en && (wptr_q == PW'(NPTS - 1));
    comp_end  = (st_q == IN_BUSY) && (pcnt_q == '0) && !clr;
    st_d   = st_q;
    wptr_d = wptr_q;
    pcnt_d = pcnt_q;
    bank_d = bank_q;
    if (clr) begin
      st_d = IN_IDLE;
    end else begin
      case (st_q)
        IN_IDLE: if (start_acc) begin
          st_d   = IN_LOAD;
          wptr_d = '0;
          bank_d = res_rdy ? ~rbank : rbank;
        end
        IN_LOAD: if (wr_en) begin
          wptr_d = wptr_q + 1'b1;
          if (last_smp) begin
            st_d   = IN_BUSY;
            pcnt_d = CW'(PROC_CYC - 1);
          end
        end
        IN_BUSY: begin
          if (comp_end) st_d = IN_IDLE;
          else          pcnt_d = pcnt_q - 1'b1;
        end
        default: st_d = IN_IDLE;
      endcase
    end
  end

  assign st_en   = clr || start_acc || last_smp || comp_end;
  assign wptr_en = start_acc || wr_en;
  assign pcnt_en = last_smp || (st_q == IN_BUSY);
  assign bank_en = start_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= IN_IDLE;
      wptr_q <= '0;
      pcnt_q <= '0;
      bank_q <= 1'b0;
    end else begin
      if (st_en)   st_q   <= st_d;
      if (wptr_en) wptr_q <= wptr_d;
      if (pcnt_en) pcnt_q <= pcnt_d;
      if (bank_en) bank_q <= bank_d;
    end
  end

  assign busy    = (st_q == IN_BUSY);
  assign wr_bank = bank_q;
  assign wr_addr = wptr_q;

  assert_busy_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(last_smp));
  assert_start_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && blk_start) |=> (st_q != IN_LOAD));
  assert_hold_blocks_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !start_acc);
endmodule

// File: rtl/xs_bank_mem.sv
module xs_bank_mem #(
  parameter int NPTS = 64,
  parameter int WW = 16,
  localparam int PW = $clog2(NPTS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [PW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [PW-1:0] rd_addr,
  output logic [WW-1:0] rd_data
);
  logic [1:0][WW-1:0] bank_rd;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WW-1:0] cells [NPTS];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) cells[wr_addr] <= wr_data;
    end
    assign bank_rd[b] = cells[rd_addr];
  end

  assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/xs_dl_ctl.sv
module xs_dl_ctl #(
  parameter int NPTS = 64,
  parameter int WW = 16,
  localparam int PW = $clog2(NPTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start_acc,
  input  logic          comp_end,
  input  logic          wbank,
  input  logic          dl_en,
  input  logic [WW-1:0] rd_data,
  output logic          done,
  output logic          res_rdy,
  output logic          rbank,
  output logic          pend,
  output logic [PW-1:0] rd_addr,
  output logic          out_vld,
  output logic          out_first,
  output logic [WW-1:0] out_data
);
  logic          rdy_q, rdy_d, rbank_q, rbank_d, pend_q, pend_d;
  logic          fresh_q, fresh_d, act_q, act_d;
  logic [PW-1:0] rptr_q, rptr_d;
  logic          ovld_q, ovld_d, ofirst_q, ofirst_d;
  logic [WW-1:0] odata_q;
  logic          dl_go, dl_last, new_load;

  always_comb begin
    done     = rdy_q && !act_q;
    dl_go    = done && dl_en && !clr;
    dl_last  = act_q && (rptr_q == PW'(NPTS - 1));
    new_load = fresh_q || (start_acc && rdy_q);
    rdy_d   = rdy_q;
    rbank_d = rbank_q;
    pend_d  = pend_q;
    fresh_d = fresh_q;
    act_d   = act_q;
    rptr_d  = rptr_q;
    if (clr) begin
      rdy_d   = 1'b0;
      pend_d  = 1'b0;
      fresh_d = 1'b0;
      act_d   = 1'b0;
    end else begin
      fresh_d = new_load;
      if (dl_go) begin
        act_d  = 1'b1;
        rptr_d = '0;
      end else if (act_q) begin
        rptr_d = rptr_q + 1'b1;
        if (dl_last) act_d = 1'b0;
      end
      if (comp_end && act_q && !dl_last) begin
        pend_d = 1'b1;
      end else if (comp_end || (dl_last && pend_q)) begin
        rbank_d = wbank;
        rdy_d   = 1'b1;
        fresh_d = 1'b0;
        pend_d  = 1'b0;
      end else if (dl_last && new_load) begin
        rdy_d = 1'b0;
      end
    end
    ovld_d   = act_q && !clr;
    ofirst_d = act_q && (rptr_q == '0) && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      rbank_q  <= 1'b0;
      pend_q   <= 1'b0;
      fresh_q  <= 1'b0;
      act_q    <= 1'b0;
      rptr_q   <= '0;
      ovld_q   <= 1'b0;
      ofirst_q <= 1'b0;
      odata_q  <= '0;
    end else begin
      rdy_q    <= rdy_d;
      rbank_q  <= rbank_d;
      pend_q   <= pend_d;
      fresh_q  <= fresh_d;
      act_q    <= act_d;
      if (dl_go || act_q) rptr_q <= rptr_d;
      ovld_q   <= ovld_d;
      ofirst_q <= ofirst_d;
      if (act_q) odata_q <= rd_data;
    end
  end

  assign res_rdy   = rdy_q;
  assign rbank     = rbank_q;
  assign pend      = pend_q;
  assign rd_addr   = rptr_q;
  assign out_vld   = ovld_q;
  assign out_first = ofirst_q;
  assign out_data  = odata_q;

  assert_dl_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld) |-> ($past(done, 2) && $past(dl_en, 2)));
  assert_first_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> !$past(out_vld));
  assert_quiet_when_not_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !act_q) |=> !act_q);
endmodule

// File: rtl/xfrm_seq.sv
module xfrm_seq #(
  parameter int NPTS = 64,
  parameter int DW = 16,
  parameter int SW = 4,
  parameter int PROC_CYC = 320
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_clr,
  input  logic          cfg_inv,
  input  logic [SW-1:0] cfg_scale,
  input  logic          blk_start,
  input  logic          in_vld,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  input  logic          dl_en,
  output logic          busy,
  output logic          done,
  output logic          out_first,
  output logic          out_vld,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im,
  output logic          mode_inv,
  output logic [SW-1:0] mode_scale
);
  localparam int PW = $clog2(NPTS);
  localparam int WW = 2 * DW;

  logic [1:0]    rsync_q;
  logic          srst_n;
  logic          inv_q;
  logic [SW-1:0] scale_q;
  logic          start_acc, wr_en, wr_bank, comp_end;
  logic          res_rdy, rbank, pend;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [WW-1:0] rd_data, out_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      inv_q   <= 1'b0;
      scale_q <= '0;
    end else if (cfg_clr) begin
      inv_q   <= cfg_inv;
      scale_q <= cfg_scale;
    end
  end
  assign mode_inv   = inv_q;
  assign mode_scale = scale_q;

  xs_load_ctl #(.NPTS(NPTS), .PROC_CYC(PROC_CYC)) u_load (
    .clk(clk), .rst_n(srst_n), .clr(cfg_clr), .blk_start(blk_start),
    .in_vld(in_vld), .res_rdy(res_rdy), .rbank(rbank), .pend(pend),
    .busy(busy), .start_acc(start_acc), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .comp_end(comp_end)
  );

  xs_bank_mem #(.NPTS(NPTS), .WW(WW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data({in_re, in_im}), .rd_bank(rbank), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  xs_dl_ctl #(.NPTS(NPTS), .WW(WW)) u_dl (
    .clk(clk), .rst_n(srst_n), .clr(cfg_clr), .start_acc(start_acc),
    .comp_end(comp_end), .wbank(wr_bank), .dl_en(dl_en), .rd_data(rd_data),
    .done(done), .res_rdy(res_rdy), .rbank(rbank), .pend(pend),
    .rd_addr(rd_addr), .out_vld(out_vld), .out_first(out_first),
    .out_data(out_data)
  );

  assign out_re = out_data[WW-1:DW];
  assign out_im = out_data[DW-1:0];

  assert_mode_capture_R2: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_clr |=> (mode_inv == $past(cfg_inv)) && (mode_scale == $past(cfg_scale)));
  assert_clear_drops_R2: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_clr |=> (!done && !busy));
endmodule

// File: tb/tb_xfrm_seq.sv
module tb_xfrm_seq;
  localparam int NPTS = 64;
  localparam int DW = 8;
  localparam int SW = 3;
  localparam int PROC = 24;

  logic clk = 1'b0;
  logic rst_n, cfg_clr, cfg_inv, blk_start, in_vld, dl_en;
  logic [SW-1:0] cfg_scale;
  logic [DW-1:0] in_re, in_im;
  logic busy, done, out_first, out_vld, mode_inv;
  logic [DW-1:0] out_re, out_im;
  logic [SW-1:0] mode_scale;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic last_done_after;
  logic [2*DW-1:0] blk [6][NPTS];

  always #4 clk = ~clk;

  xfrm_seq #(.NPTS(NPTS), .DW(DW), .SW(SW), .PROC_CYC(PROC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_clr(cfg_clr), .cfg_inv(cfg_inv),
    .cfg_scale(cfg_scale), .blk_start(blk_start), .in_vld(in_vld),
    .in_re(in_re), .in_im(in_im), .dl_en(dl_en), .busy(busy), .done(done),
    .out_first(out_first), .out_vld(out_vld), .out_re(out_re),
    .out_im(out_im), .mode_inv(mode_inv), .mode_scale(mode_scale)
  );

  function automatic int busy_len();
    return PROC;
  endfunction

  function automatic int exp_word(input int idx, input int i);
    return int'(blk[idx][i]);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_block(input int idx, input int gap);
    blk_start = 1'b1;
    tick();
    blk_start = 1'b0;
    for (int i = 0; i < NPTS; i++) begin
      while (int'($urandom_range(99)) < gap) begin
        in_vld = 1'b0;
        tick();
      end
      in_vld = 1'b1;
      {in_re, in_im} = blk[idx][i];
      tick();
    end
    in_vld = 1'b0;
  endtask

  task automatic measure_busy(input int exp_done, input bit poke);
    int cnt = 0;
    int vld_seen = 0;
    chk("R4 busy rises after last sample", int'(busy), 1);
    while (busy && cnt < 1000) begin
      if (poke) begin
        dl_en = (cnt == 2);
        blk_start = (cnt == 2);
        if (out_vld) vld_seen++;
      end
      cnt++;
      tick();
    end
    if (poke) begin
      dl_en = 1'b0;
      blk_start = 1'b0;
      chk("R12 dl_en while done low", vld_seen, 0);
    end
    chk("R4 busy length", cnt, busy_len());
    chk("R5 done after busy", int'(done), exp_done);
  endtask

  task automatic download(input int idx, input string req);
    int n = 0;
    int derr = 0;
    int ferr = 0;
    int verr = 0;
    while (!done && n < 2000) begin
      n++;
      tick();
    end
    dl_en = 1'b1;
    tick();
    dl_en = 1'b0;
    chk("R6 no output in first cycle", int'(out_vld), 0);
    for (int i = 0; i < NPTS; i++) begin
      tick();
      if (!out_vld) verr++;
      if (out_first != (i == 0)) ferr++;
      if (int'({out_re, out_im}) != exp_word(idx, i)) derr++;
      if (i == NPTS - 1) last_done_after = done;
    end
    chk("R6 valid run", verr, 0);
    chk("R6 first marker", ferr, 0);
    chk(req, derr, 0);
    tick();
    chk("R6 valid ends after 64", int'(out_vld), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bsy;
    int nd;
    void'($urandom(32'h5eed));
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < NPTS; i++) blk[b][i] = 16'($urandom);
    rst_n = 1'b0; cfg_clr = 1'b0; cfg_inv = 1'b0; cfg_scale = '0;
    blk_start = 1'b0; in_vld = 1'b0; dl_en = 1'b0; in_re = '0; in_im = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 out_vld", int'(out_vld), 0);
    chk("R1 out_first", int'(out_first), 0);
    chk("R1 mode", int'({mode_inv, mode_scale}), 0);

    cfg_clr = 1'b1; cfg_inv = 1'b1; cfg_scale = 3'd5;
    tick();
    cfg_clr = 1'b0;
    chk("R2 mode_inv", int'(mode_inv), 1);
    chk("R2 mode_scale", int'(mode_scale), 5);

    // R3 R4 R5 R9 R12: gapped load, pokes during busy
    load_block(0, 30);
    measure_busy(1, 1'b1);
    download(0, "R6 data order");
    chk("R7 done again after download", int'(last_done_after), 1);
    download(0, "R7 same data again");

    // R9 R3: the start poked during busy was ignored, stray samples too
    bsy = 0; nd = 0;
    for (int i = 0; i < NPTS; i++) begin
      in_vld = 1'b1;
      {in_re, in_im} = blk[1][i];
      tick();
      if (busy) bsy++;
      if (!done) nd++;
    end
    in_vld = 1'b0;
    chk("R9 start in busy ignored", bsy, 0);
    chk("R3 stray samples keep result", nd, 0);
    download(0, "R3 result untouched");

    // R8: new load begins together with the download
    fork
      begin load_block(1, 45); measure_busy(1, 1'b0); end
      download(0, "R8 old data during overlap");
    join
    chk("R8 no re-download after new load", int'(last_done_after), 0);
    download(1, "R8 new block data");

    // R11: undownloaded result replaced
    load_block(2, 0);
    measure_busy(1, 1'b0);
    load_block(3, 10);
    measure_busy(1, 1'b0);
    download(3, "R11 newest result");

    // R10: completion inside a download
    fork
      begin
        load_block(4, 0);
        measure_busy(0, 1'b0);
        tick(); tick();
        blk_start = 1'b1;
        tick();
        blk_start = 1'b0;
      end
      begin repeat (40) tick(); download(3, "R10 old data"); end
    join
    chk("R10 held result takes over", int'(last_done_after), 1);
    download(4, "R10 held block data");
    chk("R10 start during hold refused", int'(last_done_after), 1);
    chk("R10 no busy after refused start", int'(busy), 0);

    // R2: clear drops result and aborts a load
    cfg_clr = 1'b1; cfg_inv = 1'b0; cfg_scale = 3'd2;
    tick();
    cfg_clr = 1'b0;
    chk("R2 done dropped", int'(done), 0);
    chk("R2 mode after second clear", int'({mode_inv, mode_scale}), 2);
    blk_start = 1'b1;
    tick();
    blk_start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      in_vld = 1'b1; {in_re, in_im} = blk[5][i]; tick();
    end
    in_vld = 1'b0;
    cfg_clr = 1'b1;
    tick();
    cfg_clr = 1'b0;
    bsy = 0;
    for (int i = 10; i < NPTS + 4; i++) begin
      in_vld = (i < NPTS);
      {in_re, in_im} = blk[5][i % NPTS];
      tick();
      if (busy || done) bsy++;
    end
    in_vld = 1'b0;
    chk("R2 aborted load stays idle", bsy, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule